// File: doc/BRIEF.md
# Dual-Width Register Bus Port

This block is a synchronous slave port. It lets an external local bus reach a small window of 32-bit internal registers. A static strap input sets the bus width. At full width, each access moves a whole 32-bit word, and each of the four active-low byte enables qualifies one byte lane. In narrow mode the bus is 16 bits wide, and each register is reached as two half-words on the low data lines. The top byte-enable pin then acts as the half-word select, and the two low byte enables qualify the bytes of that half.

The address carries a dword index of five bits, which gives 32 slots. The bank behind the port holds four read/write scratch registers at indices 0 to 3 and a read-only identity word at index 4. It also holds a pass-through data register at index 16. That register always keeps its native 32-bit width, whatever the strap says. Every other index is empty.

The data lines are split into an output bus and two output enables, one for the low half and one for the high half. The enables rise in the cycle after a read is sampled. They fall as soon as the read strobe is released.

Top module: `regbus_port`

## Requirements
- R1: While `rst` is high, and after it is released, every scratch register and the pass-through register hold zero, and both output enables are low.
- R2: With `mode16`=0, a sampled write (`sel_n`=0 and `wr_n`=0 at a rising edge) stores `dq_in[8b+7:8b]` into byte b of the addressed register exactly when `be_n[b]`=0. Byte b is bits 8b+7..8b, for b from 0 to 3.
- R3: With `mode16`=1 at any address other than 16, a write takes its data from `dq_in[15:0]` and ignores `dq_in[31:16]` and `be_n[2]`. If `be_n[3]`=0, `be_n[0]` and `be_n[1]` enable register bytes 0 and 1. If `be_n[3]`=1, they enable bytes 2 and 3.
- R4: No register changes unless `sel_n` and `wr_n` are both low at the edge. A write with every relevant byte enable high leaves the register unchanged.
- R5: When a read is sampled (`sel_n`=0 and `rd_n`=0 at a rising edge), `dq_out` carries the read data after that edge, and the enables are high while `rd_n` stays low. Both enables are low at any time `rd_n` is high. In 32-bit mode, both enables rise and `dq_out[31:0]` is the whole register.
- R6: With `mode16`=1 at any address other than 16, a read drives the selected half on `dq_out[15:0]`. That half is bits [15:0] when `be_n[3]`=0 and bits [31:16] when `be_n[3]`=1. Only `dq_oe_lo` rises, and `dq_oe_hi` stays low.
- R7: Address 16 (the pass-through data register) always uses full 32-bit access. Its writes follow R2 with all four byte enables, and its reads follow R5 with both enables high, whatever `mode16` says.
- R8: Indices 5 to 15 and 17 to 31 read as zero and ignore writes. Index 4 reads as 32'h5A1C0001 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode16 | input | 1 | Width strap: 1 = 16-bit bus, 0 = 32-bit bus |
| sel_n | input | 1 | Active-low port select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 5 | Dword register index |
| be_n | input | 4 | Active-low byte enables; bit 3 is the half select in 16-bit mode |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data toward the bus |
| dq_oe_lo | output | 1 | Drive enable for data lines [15:0] |
| dq_oe_hi | output | 1 | Drive enable for data lines [31:16] |

## Verification
A write lands at the rising edge that samples it, so the bench issues a read of the same register on a later cycle and checks the stored value through it. Read data and enables come from one register stage, so the bench samples `dq_out` and the enables 2 ns after the edge that sampled the read, while `rd_n` is still low. It then releases `rd_n` on the falling edge and checks 1 ns later that both enables have dropped. The bench changes the width strap only between accesses. After the 16-bit sweep it reads every index back at full width, so the half-word steering is checked against plain 32-bit access.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
    localparam int BYTES  = 4;
    localparam int WORD_W = 8 * BYTES;
    localparam int HALF_W = WORD_W / 2;
    localparam int HB     = BYTES / 2;
    localparam int ADDR_W = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTES-1:0]  lanes_t;
    typedef logic [ADDR_W-1:0] idx_t;

    typedef struct packed {
        word_t  data;
        lanes_t mask;
    } wr_req_t;

    typedef struct packed {
        word_t data;
        logic  oe_lo;
        logic  oe_hi;
    } rd_beat_t;

    function automatic word_t merge_lanes(word_t old_v, word_t new_v, lanes_t m);
        word_t r;
        r = old_v;
        for (int b = 0; b < BYTES; b++)
            if (m[b]) r[8*b +: 8] = new_v[8*b +: 8];
        return r;
    endfunction
endpackage

// File: rtl/regbus_steer.sv
module regbus_steer
    import regbus_pkg::*;
(
    input  logic     native,
    input  lanes_t   be_n,
    input  word_t    dq_in,
    input  word_t    rdata,
    output wr_req_t  wreq,
    output rd_beat_t rbeat
);
    logic upper;
    assign upper = be_n[BYTES-1];

    always_comb begin
        wreq  = '0;
        rbeat = '0;
        if (native) begin
            wreq.data   = dq_in;
            wreq.mask   = ~be_n;
            rbeat.data  = rdata;
            rbeat.oe_lo = 1'b1;
            rbeat.oe_hi = 1'b1;
        end else begin
            wreq.data = {2{dq_in[HALF_W-1:0]}};
            if (upper) wreq.mask[BYTES-1:HB] = ~be_n[HB-1:0];
            else       wreq.mask[HB-1:0]     = ~be_n[HB-1:0];
            rbeat.data  = {{HALF_W{1'b0}},
                           upper ? rdata[WORD_W-1:HALF_W] : rdata[HALF_W-1:0]};
            rbeat.oe_lo = 1'b1;
            rbeat.oe_hi = 1'b0;
        end
    end

    // R3: a half-word access never touches both halves of the register
    always_comb begin
        if (!native)
            a_half_exclusive_r3: assert (wreq.mask[BYTES-1:HB] == '0 || wreq.mask[HB-1:0] == '0);
    end
endmodule

// File: rtl/regbus_bank.sv
module regbus_bank
    import regbus_pkg::*;
#(
    parameter int    NUM_RW = 4,
    parameter int    ID_IDX = 4,
    parameter int    PT_IDX = 16,
    parameter word_t ID_VAL = 32'h5A1C_0001
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  idx_t    addr,
    input  wr_req_t wreq,
    output word_t   rdata
);
    word_t rw_q [NUM_RW];
    word_t pt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_RW; i++) rw_q[i] <= '0;
            pt_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_RW; i++)
                if (addr == idx_t'(i)) rw_q[i] <= merge_lanes(rw_q[i], wreq.data, wreq.mask);
            if (addr == idx_t'(PT_IDX)) pt_q <= merge_lanes(pt_q, wreq.data, wreq.mask);
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_RW; i++)
            if (addr == idx_t'(i)) rdata = rw_q[i];
        if (addr == idx_t'(ID_IDX)) rdata = ID_VAL;
        if (addr == idx_t'(PT_IDX)) rdata = pt_q;
    end

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_hold
            // R4: no strobe or no enabled byte means the register keeps its value
            p_hold_r4: assert property (@(posedge clk) disable iff (rst)
                (!wr_en || wreq.mask == '0 || addr != idx_t'(g)) |=> $stable(rw_q[g]));
        end
    endgenerate
endmodule

// File: rtl/regbus_rdout.sv
module regbus_rdout
    import regbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fire,
    input  logic     rd_n,
    input  rd_beat_t nxt,
    output word_t    dq_out,
    output logic     oe_lo,
    output logic     oe_hi
);
    rd_beat_t q;

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (fire) q <= nxt;
        else           q <= '0;
    end

    assign dq_out = q.data;
    assign oe_lo  = q.oe_lo & ~rd_n;
    assign oe_hi  = q.oe_hi & ~rd_n;

    p_oe_follows_read_r5: assert property (@(posedge clk) disable iff (rst)
        (oe_lo || oe_hi) |-> $past(fire));
endmodule

// File: rtl/regbus_port.sv
module regbus_port
    import regbus_pkg::*;
#(
    parameter int    NUM_RW = 4,
    parameter int    ID_IDX = 4,
    parameter int    PT_IDX = 16,
    parameter word_t ID_VAL = 32'h5A1C_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode16,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTES-1:0]  be_n,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi
);
    logic     is_pt, native, wr_en, fire;
    word_t    rdata;
    wr_req_t  wreq;
    rd_beat_t rbeat;

    assign is_pt  = (addr == idx_t'(PT_IDX));
    assign native = !mode16 || is_pt;
    assign wr_en  = !sel_n && !wr_n;
    assign fire   = !sel_n && !rd_n;

    regbus_steer u_steer (
        .native(native), .be_n(be_n), .dq_in(dq_in),
        .rdata(rdata), .wreq(wreq), .rbeat(rbeat)
    );

    regbus_bank #(.NUM_RW(NUM_RW), .ID_IDX(ID_IDX), .PT_IDX(PT_IDX), .ID_VAL(ID_VAL)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wreq(wreq), .rdata(rdata)
    );

    regbus_rdout u_rdout (
        .clk(clk), .rst(rst), .fire(fire), .rd_n(rd_n), .nxt(rbeat),
        .dq_out(dq_out), .oe_lo(dq_oe_lo), .oe_hi(dq_oe_hi)
    );

    p_hi_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && mode16 && !is_pt) |=> !dq_oe_hi);

    p_pt_wide_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && is_pt) |=> (rd_n || (dq_oe_hi && dq_oe_lo)));

    p_read_enables_r5: assert property (@(posedge clk) disable iff (rst)
        fire |=> (rd_n || dq_oe_lo));

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && int'(addr) >= NUM_RW && addr != idx_t'(ID_IDX) && !is_pt) |=> dq_out == '0);
endmodule

// File: tb/tb_regbus_port.sv
`timescale 1ns/1ps
module tb_regbus_port;
    localparam logic [31:0] ID_VAL = 32'h5A1C_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode16 = 1'b0;
    logic        sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [4:0]  addr = '0;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] dq_in = '0;
    logic [31:0] dq_out;
    logic        dq_oe_lo, dq_oe_hi;

    int total = 0;
    int bad = 0;
    logic [31:0] model [32];
    logic [31:0] got_d;
    logic        got_lo, got_hi;

    regbus_port dut (
        .clk(clk), .rst(rst), .mode16(mode16), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .be_n(be_n), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic bit writable(int i);
        return (i < 4) || (i == 16);
    endfunction

    function automatic logic [31:0] expect_rd(int i);
        if (writable(i)) return model[i];
        if (i == 4) return ID_VAL;
        return 32'h0;
    endfunction

    task automatic model_write(int i, logic [31:0] d, logic [3:0] m);
        if (writable(i))
            for (int b = 0; b < 4; b++)
                if (m[b]) model[i][8*b +: 8] = d[8*b +: 8];
    endtask

    task automatic bus_write(int i, logic [3:0] ben, logic [31:0] d);
        @(negedge clk);
        sel_n = 1'b0; wr_n = 1'b0; addr = 5'(i); be_n = ben; dq_in = d;
        @(negedge clk);
        sel_n = 1'b1; wr_n = 1'b1; be_n = 4'hF;
    endtask

    task automatic bus_read(int i, logic [3:0] ben, input string req);
        @(negedge clk);
        sel_n = 1'b0; rd_n = 1'b0; addr = 5'(i); be_n = ben;
        @(posedge clk);
        #2;
        got_d = dq_out; got_lo = dq_oe_lo; got_hi = dq_oe_hi;
        @(negedge clk);
        rd_n = 1'b1; sel_n = 1'b1;
        #1;
        check({req, " enables released (R5)"}, {30'b0, dq_oe_hi, dq_oe_lo}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 enables in reset", {30'b0, dq_oe_hi, dq_oe_lo}, 32'h0);
        @(negedge clk); rst = 1'b0;

        // R1 / R8: reset contents
        for (int i = 0; i < 32; i++) begin
            bus_read(i, 4'h0, "R1");
            check("R1 reset value", got_d, expect_rd(i));
        end

        // R2 / R4 / R5 / R8: 32-bit mode, every index and every byte-enable pattern
        for (int i = 0; i < 32; i++) begin
            for (int be = 0; be < 16; be++) begin
                logic [31:0] d;
                d = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101) ^ (32'(be) << 20) ^ 32'(be * 7);
                bus_write(i, 4'(be), d);
                model_write(i, d, ~4'(be));
                bus_read(i, 4'h0, "R2");
                check("R2 32-bit write/read", got_d, expect_rd(i));
                check("R5 both enables", {30'b0, got_hi, got_lo}, 32'h3);
            end
        end

        // R4: strobes without select, select without strobe
        @(negedge clk);
        sel_n = 1'b1; wr_n = 1'b0; addr = 5'd1; be_n = 4'h0; dq_in = 32'hFFFF_FFFF;
        @(negedge clk);
        sel_n = 1'b0; wr_n = 1'b1;
        @(negedge clk);
        sel_n = 1'b1; wr_n = 1'b1;
        bus_read(1, 4'h0, "R4");
        check("R4 unqualified write ignored", got_d, model[1]);

        // R3 / R6 / R7 / R8: 16-bit mode sweep
        @(negedge clk); mode16 = 1'b1;
        for (int i = 0; i < 32; i++) begin
            if (i == 16) continue;
            for (int h = 0; h < 2; h++) begin
                for (int bl = 0; bl < 4; bl++) begin
                    logic [15:0] d16;
                    logic [3:0]  m;
                    d16 = 16'hC3A0 ^ 16'(i * 16'h0123) ^ 16'(h << 15) ^ 16'(bl * 16'h0011);
                    bus_write(i, {1'(h), 1'b0, ~2'(bl)}, {16'hDEAD, d16});
                    m = h[0] ? {2'(bl), 2'b00} : {2'b00, 2'(bl)};
                    model_write(i, {d16, d16}, m);
                    bus_read(i, {1'(h), 3'b000}, "R6");
                    check("R3/R6 half-word read", {16'h0, got_d[15:0]},
                          {16'h0, h[0] ? expect_rd(i)[31:16] : expect_rd(i)[15:0]});
                    check("R6 only low enable", {30'b0, got_hi, got_lo}, 32'h1);
                end
            end
        end

        // R7: pass-through register keeps full width in 16-bit mode
        bus_write(16, 4'h0, 32'hA1B2_C3D4);
        model_write(16, 32'hA1B2_C3D4, 4'hF);
        bus_write(16, 4'b0111, 32'h5E00_0000);
        model_write(16, 32'h5E00_0000, 4'b1000);
        bus_read(16, 4'h0, "R7");
        check("R7 native width data", got_d, model[16]);
        check("R7 both enables", {30'b0, got_hi, got_lo}, 32'h3);

        // R3 vs R2: read everything back at full width
        @(negedge clk); mode16 = 1'b0;
        for (int i = 0; i < 32; i++) begin
            bus_read(i, 4'h0, "R3");
            check("R3 halves match 32-bit view", got_d, expect_rd(i));
        end

        // R1: reset clears written contents
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        bus_read(0, 4'h0, "R1");
        check("R1 cleared after reset", got_d, 32'h0);
        bus_read(16, 4'h0, "R1");
        check("R1 pass-through cleared", got_d, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule